// File: doc/BRIEF.md
# Two-Side Mailbox Bridge

The bridge links two processors that share one clock. Each processor sees its own window of four 32-bit registers. A doorbell register carries one byte from each side to the other. It also lets either side raise a one-cycle doorbell interrupt on a processor that has armed it. A control register reports the state of two word FIFOs and holds the interrupt enables, a flush command, a FIFO enable and a sticky error flag. The last two registers are a push port into the local outbound FIFO and a pop port from the inbound FIFO that the peer fills.

There are two word FIFOs, one for each direction. The FIFO written by one side's push port is the same storage that the other side's pop port drains. A flush or a pop on either side is therefore seen at once by both banks. Each access port has a select, a write flag, a two-bit word index, byte strobes and write data. Read data is combinational for the word that is addressed. A pop takes effect at the clock edge that ends the read access.

Top module: `ipc_mailbox_bridge`

## Requirements
- R1: The word index selects the register: 0 is doorbell, 1 is control, 2 is push port, 3 is pop port. One read or write per side per cycle.
- R2: Doorbell bits 15:8 are writable through byte strobe 1 and read back locally. The peer reads the same byte in its doorbell bits 7:0. A write whose strobe 1 is clear leaves the byte unchanged.
- R3: A write with strobe 3 set and data bit 29 set raises side B's doorbell interrupt for exactly one cycle, starting after the write edge. Data bit 30 does the same for side A. The pulse appears only when the target's doorbell bit 31 (its arm bit) is 1.
- R4: Control bit 0 reads 1 when the local outbound FIFO is empty, and bit 1 reads 1 when it holds 16 words. Words leave the FIFO in the order they were pushed.
- R5: Control bit 8 reads 1 when the inbound FIFO is empty, and bit 9 reads 1 when it is full. A read of the pop port while enabled removes one word.
- R6: The send interrupt output equals outbound-empty AND control bit 2.
- R7: The receive interrupt output equals inbound-not-empty AND control bit 10.
- R8: Writing 1 to control bit 3 (strobe 0) empties the local outbound FIFO, so the peer's inbound view also becomes empty.
- R9: Control bit 14 becomes 1 and stays 1 when an enabled side pushes into a full FIFO or pops an empty one. Writing 1 to bit 14 (strobe 1) clears it. The word pushed into a full FIFO is dropped. A pop of an empty FIFO returns the last word that was popped.
- R10: While control bit 15 is 0, pushes are ignored and pop-port reads remove nothing and set no error.
- R11: After reset both FIFOs are empty, all enables and doorbell bytes are 0, the error flags are 0, and every interrupt output is low. A control read then returns 0x0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access valid |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 2 | Side A register word index |
| a_be | input | 4 | Side A byte strobes |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq_sync | output | 1 | Side A doorbell interrupt pulse |
| a_irq_send | output | 1 | Side A outbound-empty interrupt |
| a_irq_recv | output | 1 | Side A inbound-data interrupt |
| b_sel | input | 1 | Side B access valid |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 2 | Side B register word index |
| b_be | input | 4 | Side B byte strobes |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq_sync | output | 1 | Side B doorbell interrupt pulse |
| b_irq_send | output | 1 | Side B outbound-empty interrupt |
| b_irq_recv | output | 1 | Side B inbound-data interrupt |

## Verification
The assertions assume that a side's select, write flag, index, strobes and data are known and stay steady through the clock edge that ends an access. They also assume that a doorbell trigger is only ever recognised through a write with strobe 3 set. The stimulus changes every input on the falling edge and holds it for a full cycle. It drops the select after each access, so every doorbell pulse and every FIFO state change traces back to exactly one write or read. Both sides are driven one after the other and never in the same cycle. This keeps a doorbell pulse tied to a single known trigger.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   localparam logic [1:0] REG_SYNC = 2'd0;
   localparam logic [1:0] REG_CTRL = 2'd1;
   localparam logic [1:0] REG_PUSH = 2'd2;
   localparam logic [1:0] REG_POP  = 2'd3;

   localparam int unsigned SY_TRIG_B = 29;
   localparam int unsigned SY_TRIG_A = 30;
   localparam int unsigned SY_ARM    = 31;

   localparam int unsigned CT_TX_EMPTY = 0;
   localparam int unsigned CT_TX_FULL  = 1;
   localparam int unsigned CT_TX_IEN   = 2;
   localparam int unsigned CT_FLUSH    = 3;
   localparam int unsigned CT_RX_EMPTY = 8;
   localparam int unsigned CT_RX_FULL  = 9;
   localparam int unsigned CT_RX_IEN   = 10;
   localparam int unsigned CT_ERR      = 14;
   localparam int unsigned CT_EN       = 15;
endpackage

// File: rtl/ipc_word_fifo.sv
module ipc_word_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   input  logic             flush,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign head  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full && !flush) mem[wp[AW-1:0]] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/ipc_side_bank.sv
module ipc_side_bank
   import ipc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_sel,
   input  logic              acc_wr,
   input  logic [1:0]        acc_addr,
   input  logic [3:0]        acc_be,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              tx_empty,
   input  logic              tx_full,
   input  logic              rx_empty,
   input  logic              rx_full,
   input  logic [DATA_W-1:0] rx_head,
   input  logic [7:0]        peer_byte,
   output logic [7:0]        own_byte,
   output logic              arm,
   output logic              trig_a,
   output logic              trig_b,
   output logic              tx_push,
   output logic              tx_flush,
   output logic              rx_pop,
   output logic              irq_send,
   output logic              irq_recv
);
   logic wr_hit, rd_hit, sync_wr, ctrl_wr, push_wr, pop_rd;
   logic tx_ien, rx_ien, fifo_en, err, err_set, err_clr;
   logic [DATA_W-1:0] last_word;

   assign wr_hit  = acc_sel && acc_wr;
   assign rd_hit  = acc_sel && !acc_wr;
   assign sync_wr = wr_hit && (acc_addr == REG_SYNC);
   assign ctrl_wr = wr_hit && (acc_addr == REG_CTRL);
   assign push_wr = wr_hit && (acc_addr == REG_PUSH);
   assign pop_rd  = rd_hit && (acc_addr == REG_POP);

   assign tx_push  = push_wr && fifo_en && !tx_full;
   assign rx_pop   = pop_rd && fifo_en && !rx_empty;
   assign tx_flush = ctrl_wr && acc_be[0] && acc_wdata[CT_FLUSH];
   assign trig_b   = sync_wr && acc_be[3] && acc_wdata[SY_TRIG_B];
   assign trig_a   = sync_wr && acc_be[3] && acc_wdata[SY_TRIG_A];
   assign err_set  = fifo_en && ((push_wr && tx_full) || (pop_rd && rx_empty));
   assign err_clr  = ctrl_wr && acc_be[1] && acc_wdata[CT_ERR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_byte <= '0;
         arm      <= 1'b0;
         tx_ien   <= 1'b0;
         rx_ien   <= 1'b0;
         fifo_en  <= 1'b0;
      end else begin
         if (sync_wr && acc_be[1]) own_byte <= acc_wdata[15:8];
         if (sync_wr && acc_be[3]) arm      <= acc_wdata[SY_ARM];
         if (ctrl_wr && acc_be[0]) tx_ien   <= acc_wdata[CT_TX_IEN];
         if (ctrl_wr && acc_be[1]) begin
            rx_ien  <= acc_wdata[CT_RX_IEN];
            fifo_en <= acc_wdata[CT_EN];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       err <= 1'b0;
      else if (err_set) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      last_word <= '0;
      else if (rx_pop) last_word <= rx_head;
   end

   always_comb begin
      acc_rdata = '0;
      unique case (acc_addr)
         REG_SYNC: begin
            acc_rdata[7:0]    = peer_byte;
            acc_rdata[15:8]   = own_byte;
            acc_rdata[SY_ARM] = arm;
         end
         REG_CTRL: begin
            acc_rdata[CT_TX_EMPTY] = tx_empty;
            acc_rdata[CT_TX_FULL]  = tx_full;
            acc_rdata[CT_TX_IEN]   = tx_ien;
            acc_rdata[CT_RX_EMPTY] = rx_empty;
            acc_rdata[CT_RX_FULL]  = rx_full;
            acc_rdata[CT_RX_IEN]   = rx_ien;
            acc_rdata[CT_ERR]      = err;
            acc_rdata[CT_EN]       = fifo_en;
         end
         REG_PUSH: acc_rdata = '0;
         default:  acc_rdata = rx_empty ? last_word : rx_head;
      endcase
   end

   assign irq_send = tx_ien && tx_empty;
   assign irq_recv = rx_ien && !rx_empty;
endmodule

// File: rtl/ipc_mailbox_bridge.sv
module ipc_mailbox_bridge #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic [1:0]        a_addr,
   input  logic [3:0]        a_be,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_irq_sync,
   output logic              a_irq_send,
   output logic              a_irq_recv,
   input  logic              b_sel,
   input  logic              b_wr,
   input  logic [1:0]        b_addr,
   input  logic [3:0]        b_be,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_irq_sync,
   output logic              b_irq_send,
   output logic              b_irq_recv
);
   localparam int unsigned SIDES = 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("ipc_mailbox_bridge: DATA_W must be 32");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ipc_mailbox_bridge: DEPTH must be a power of two >= 2");
   end

   logic [SIDES-1:0]             sel_v, wr_v;
   logic [SIDES-1:0][1:0]        addr_v;
   logic [SIDES-1:0][3:0]        be_v;
   logic [SIDES-1:0][DATA_W-1:0] wdata_v, rdata_v, head_v;
   logic [SIDES-1:0][7:0]        byte_v;
   logic [SIDES-1:0]             fifo_empty, fifo_full;
   logic [SIDES-1:0]             push_v, flush_v, pop_v, arm_v;
   logic [SIDES-1:0]             trig_a_v, trig_b_v;
   logic [SIDES-1:0]             irq_send_v, irq_recv_v, sync_q;
   logic [SIDES-1:0]             hit_v;

   assign sel_v   = {b_sel, a_sel};
   assign wr_v    = {b_wr, a_wr};
   assign addr_v  = {b_addr, a_addr};
   assign be_v    = {b_be, a_be};
   assign wdata_v = {b_wdata, a_wdata};
   assign hit_v   = {|trig_b_v, |trig_a_v};

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      localparam int unsigned PEER = SIDES - 1 - s;

      ipc_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push_v[s]),
         .push_data (wdata_v[s]),
         .pop       (pop_v[PEER]),
         .flush     (flush_v[s]),
         .head      (head_v[s]),
         .empty     (fifo_empty[s]),
         .full      (fifo_full[s])
      );

      ipc_side_bank #(.DATA_W(DATA_W)) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_sel   (sel_v[s]),
         .acc_wr    (wr_v[s]),
         .acc_addr  (addr_v[s]),
         .acc_be    (be_v[s]),
         .acc_wdata (wdata_v[s]),
         .acc_rdata (rdata_v[s]),
         .tx_empty  (fifo_empty[s]),
         .tx_full   (fifo_full[s]),
         .rx_empty  (fifo_empty[PEER]),
         .rx_full   (fifo_full[PEER]),
         .rx_head   (head_v[PEER]),
         .peer_byte (byte_v[PEER]),
         .own_byte  (byte_v[s]),
         .arm       (arm_v[s]),
         .trig_a    (trig_a_v[s]),
         .trig_b    (trig_b_v[s]),
         .tx_push   (push_v[s]),
         .tx_flush  (flush_v[s]),
         .rx_pop    (pop_v[s]),
         .irq_send  (irq_send_v[s]),
         .irq_recv  (irq_recv_v[s])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else        sync_q[s] <= hit_v[s] && arm_v[s];
      end
   end

   assign a_rdata    = rdata_v[0];
   assign b_rdata    = rdata_v[1];
   assign a_irq_sync = sync_q[0];
   assign b_irq_sync = sync_q[1];
   assign a_irq_send = irq_send_v[0];
   assign b_irq_send = irq_send_v[1];
   assign a_irq_recv = irq_recv_v[0];
   assign b_irq_recv = irq_recv_v[1];
endmodule

// File: rtl/ipc_mailbox_checker.sv
module ipc_mailbox_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        a_sel,
   input logic        a_wr,
   input logic [1:0]  a_addr,
   input logic [3:0]  a_be,
   input logic [31:0] a_wdata,
   input logic        b_sel,
   input logic        b_wr,
   input logic [1:0]  b_addr,
   input logic [3:0]  b_be,
   input logic [31:0] b_wdata,
   input logic        a_irq_sync,
   input logic        b_irq_sync,
   input logic        a_irq_send,
   input logic        b_irq_send,
   input logic        a_irq_recv,
   input logic        b_irq_recv,
   input logic [1:0]  fifo_empty,
   input logic [1:0]  fifo_full
);
   logic a_sync_wr, b_sync_wr, a_flush_wr, b_flush_wr;
   assign a_sync_wr  = a_sel && a_wr && a_addr == 2'd0 && a_be[3];
   assign b_sync_wr  = b_sel && b_wr && b_addr == 2'd0 && b_be[3];
   assign a_flush_wr = a_sel && a_wr && a_addr == 2'd1 && a_be[0] && a_wdata[3];
   assign b_flush_wr = b_sel && b_wr && b_addr == 2'd1 && b_be[0] && b_wdata[3];

   a_r4_fifo0_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty[0] && fifo_full[0]));
   a_r4_fifo1_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty[1] && fifo_full[1]));
   a_r6_a_send_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq_send |-> fifo_empty[0]);
   a_r6_b_send_irq_empty: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq_send |-> fifo_empty[1]);
   a_r7_a_recv_irq_data: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq_recv |-> !fifo_empty[1]);
   a_r7_b_recv_irq_data: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq_recv |-> !fifo_empty[0]);
   a_r3_b_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_irq_sync) |-> $past((a_sync_wr && a_wdata[29]) || (b_sync_wr && b_wdata[29])));
   a_r3_a_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_irq_sync) |-> $past((a_sync_wr && a_wdata[30]) || (b_sync_wr && b_wdata[30])));
   a_r8_a_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      a_flush_wr |=> fifo_empty[0]);
   a_r8_b_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      b_flush_wr |=> fifo_empty[1]);
endmodule

bind ipc_mailbox_bridge ipc_mailbox_checker i_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_sel      (a_sel),
   .a_wr       (a_wr),
   .a_addr     (a_addr),
   .a_be       (a_be),
   .a_wdata    (a_wdata),
   .b_sel      (b_sel),
   .b_wr       (b_wr),
   .b_addr     (b_addr),
   .b_be       (b_be),
   .b_wdata    (b_wdata),
   .a_irq_sync (a_irq_sync),
   .b_irq_sync (b_irq_sync),
   .a_irq_send (a_irq_send),
   .b_irq_send (b_irq_send),
   .a_irq_recv (a_irq_recv),
   .b_irq_recv (b_irq_recv),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/test_ipc_mailbox_bridge.sv
module test_ipc_mailbox_bridge;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
   logic [1:0] a_addr = 0, b_addr = 0;
   logic [3:0] a_be = 0, b_be = 0;
   logic [31:0] a_wdata = 0, b_wdata = 0;
   logic [31:0] a_rdata, b_rdata;
   logic a_irq_sync, a_irq_send, a_irq_recv, b_irq_sync, b_irq_send, b_irq_recv;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ipc_mailbox_bridge i_ipc_mailbox_bridge (
      .clk(clk), .rst_n(rst_n),
      .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_irq_sync(a_irq_sync), .a_irq_send(a_irq_send), .a_irq_recv(a_irq_recv),
      .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_irq_sync(b_irq_sync), .b_irq_send(b_irq_send), .b_irq_recv(b_irq_recv)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic acc(input bit side, input bit wr, input logic [1:0] addr,
                      input logic [3:0] be, input logic [31:0] d, output logic [31:0] rd);
      @(negedge clk);
      if (side) begin b_sel = 1; b_wr = wr; b_addr = addr; b_be = be; b_wdata = d; end
      else      begin a_sel = 1; a_wr = wr; a_addr = addr; a_be = be; a_wdata = d; end
      #2 rd = side ? b_rdata : a_rdata;
      @(negedge clk);
      a_sel = 0; b_sel = 0;
   endtask

   task automatic wr(input bit side, input logic [1:0] addr, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] unused;
      acc(side, 1'b1, addr, be, d, unused);
   endtask

   task automatic rd(input bit side, input logic [1:0] addr, output logic [31:0] r);
      acc(side, 1'b0, addr, 4'hF, 32'h0, r);
   endtask

   task automatic t_reset();
      logic [31:0] r;
      rd(0, 2'd1, r); chk("R11 ctrl A after reset", r, 32'h0000_0101);
      rd(1, 2'd0, r); chk("R11 sync B after reset", r, 32'h0);
      chk("R11 irq outputs low", {a_irq_sync, a_irq_send, a_irq_recv, b_irq_sync, b_irq_send, b_irq_recv}, 0);
   endtask

   task automatic t_sync_byte();
      logic [31:0] r;
      wr(0, 2'd0, 4'b0010, 32'h0000_5A00);
      rd(1, 2'd0, r); chk("R2 peer byte at B bits 7:0 (R1 index 0)", r & 32'hFF, 32'h5A);
      rd(0, 2'd0, r); chk("R2 own byte at A bits 15:8", (r >> 8) & 32'hFF, 32'h5A);
      wr(0, 2'd0, 4'b0001, 32'h0000_FF00);
      rd(1, 2'd0, r); chk("R2 strobe 1 clear keeps byte", r & 32'hFF, 32'h5A);
   endtask

   task automatic t_sync_irq();
      wr(1, 2'd0, 4'b1000, 32'h8000_0000);
      wr(0, 2'd0, 4'b1000, 32'h2000_0000);
      chk("R3 B pulse after bit 29 write", b_irq_sync, 1);
      @(negedge clk);
      chk("R3 B pulse one cycle only", b_irq_sync, 0);
      wr(1, 2'd0, 4'b1000, 32'hC000_0000);
      chk("R3 A not armed no pulse", a_irq_sync, 0);
   endtask

   task automatic t_fifo_order();
      logic [31:0] r;
      wr(0, 2'd2, 4'hF, 32'h1111_1111);
      rd(0, 2'd1, r); chk("R10 disabled push ignored", r & 32'h1, 32'h1);
      wr(0, 2'd1, 4'b0011, 32'h0000_8000);
      wr(1, 2'd1, 4'b0011, 32'h0000_8000);
      for (int i = 0; i < 3; i++) wr(0, 2'd2, 4'hF, 32'hC0DE_0000 + i);
      rd(1, 2'd1, r); chk("R5 B inbound not empty", r & 32'h100, 32'h0);
      for (int i = 0; i < 3; i++) begin
         rd(1, 2'd3, r); chk("R4 order preserved", r, 32'hC0DE_0000 + i);
      end
      rd(1, 2'd1, r); chk("R5 B inbound empty after pops", r & 32'h100, 32'h100);
   endtask

   task automatic t_full_err();
      logic [31:0] r;
      for (int i = 0; i < 16; i++) wr(0, 2'd2, 4'hF, 32'hA000_0000 + i);
      rd(0, 2'd1, r); chk("R4 A outbound full bit 1", r & 32'h3, 32'h2);
      rd(1, 2'd1, r); chk("R5 B inbound full bit 9", r & 32'h300, 32'h200);
      wr(0, 2'd2, 4'hF, 32'hDEAD_BEEF);
      rd(0, 2'd1, r); chk("R9 A error on full push", (r >> 14) & 1, 1);
      for (int i = 0; i < 16; i++) begin
         rd(1, 2'd3, r); chk("R9 drained word, overflow dropped", r, 32'hA000_0000 + i);
      end
      rd(1, 2'd3, r); chk("R9 empty pop returns last word", r, 32'hA000_000F);
      rd(1, 2'd1, r); chk("R9 B error on empty pop", (r >> 14) & 1, 1);
      wr(1, 2'd1, 4'b0010, 32'h0000_C000);
      rd(1, 2'd1, r); chk("R9 write 1 clears error", (r >> 14) & 1, 0);
      rd(0, 2'd1, r); chk("R9 A error still sticky", (r >> 14) & 1, 1);
   endtask

   task automatic t_irq_flush();
      logic [31:0] r;
      wr(0, 2'd1, 4'b0011, 32'h0000_8004);
      chk("R6 send irq on empty and enabled", a_irq_send, 1);
      wr(1, 2'd1, 4'b0011, 32'h0000_8400);
      chk("R7 no recv irq while empty", b_irq_recv, 0);
      wr(0, 2'd2, 4'hF, 32'h0000_0077);
      chk("R7 recv irq with data", b_irq_recv, 1);
      chk("R6 send irq drops when not empty", a_irq_send, 0);
      wr(0, 2'd1, 4'b0001, 32'h0000_000C);
      rd(1, 2'd1, r); chk("R8 flush empties peer view", r & 32'h100, 32'h100);
      chk("R8 recv irq gone after flush", b_irq_recv, 0);
   endtask

   task automatic t_disabled_pop();
      logic [31:0] r;
      wr(0, 2'd2, 4'hF, 32'h0000_5555);
      wr(1, 2'd1, 4'b0011, 32'h0000_0000);
      rd(1, 2'd3, r); chk("R10 disabled read sees head", r, 32'h5555);
      rd(1, 2'd1, r); chk("R10 disabled read no pop no error", r & 32'h4100, 32'h0);
      wr(1, 2'd1, 4'b0011, 32'h0000_8000);
      rd(1, 2'd3, r); chk("R5 enabled read returns word", r, 32'h5555);
      rd(1, 2'd1, r); chk("R5 popped to empty", r & 32'h100, 32'h100);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_sync_byte();
      t_sync_irq();
      t_fifo_order();
      t_full_err();
      t_irq_flush();
      t_disabled_pop();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule